// File: doc/BRIEF.md
# Three-Bank Flash Command Controller

This block is the bus front end and command logic of a memory with two flash banks and one EEPROM-style bank. The external bus is asynchronous in style: three active-low bank selects, an active-low output enable, an active-low write enable, an address and a write-data word. A fast internal clock samples the bus and decodes reads and write cycles from it. Each bank's storage is a small register array, so the block models behaviour and not cell physics.

A write to any bank needs a three-cycle unlock sequence. Every cycle of that sequence must use the same bank select. The third cycle either arms a single-word program or starts a whole-bank erase. Once an operation is launched, its bank stays busy for a fixed, parameter-set number of clocks. Only one bank may be busy at a time. The other banks keep serving reads while it is busy.

Software can poll a status word in the EEPROM bank's space. An identification word can be read from the first flash bank while no bank is busy. The read data bus is tri-state in behaviour, so it comes with a drive-enable output.

Top module: `mbank_cmd_ctrl`

## Requirements
- R1: A read is served only when exactly one bank select is low, output enable is low and write enable is high. The word at index `addr[3:0]` of the selected bank then appears on `rdata` with `rdata_drive` high. Whenever output enable is high, `rdata_drive` is low.
- R2: While two or more bank selects are low, `rdata_drive` is low and no write cycle is recognised. A write that overlaps like this has no effect.
- R3: The address of a write cycle is taken when write enable and the bank select are first both low, which is the later of their two falling edges. The data is taken when both are high again, which is the later of their two rising edges, and that moment completes the cycle. Either edge order works.
- R4: The unlock sequence is three write cycles: (0x5555, 0x00AA), then (0x2AAA, 0x0055), then 0x5555 with a command word. Command 0x00A0 arms a program: the next write cycle stores its data at `addr[3:0]` of that bank. Command 0x0010 sets every word of the bank to 0xFFFF. Any other pair returns the tracker to idle and nothing executes.
- R5: A write cycle on a different bank select in the middle of a sequence abandons the sequence. The pending command never executes. That cycle may itself begin a new sequence.
- R6: A launched program or erase makes its bank busy for BUSY_CYCLES clocks. At most one bank is busy at any time.
- R7: A program or erase that would launch while any bank is busy is dropped. It also sets `cmd_err`, which stays high until reset.
- R8: While one bank is busy, reads of the other banks return their data. Reads of the busy bank are not driven.
- R9: A read of the EEPROM bank (select index 2) with `addr[15:12]` = 0x5 returns the status word instead of array data. Bit i of that word is set while bank i is busy, and the upper bits are zero.
- R10: A read of bank 0 with `addr[15:12]` = 0xF returns ID_WORD (default 0x00C5) while no bank is busy. It is not driven while any bank is busy.
- R11: After reset every array word reads 0xFFFF, `cmd_err` is low, `rdata_drive` is low and the tracker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel_n | input | NB (3) | Active-low bank selects; index 2 is the EEPROM bank |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| addr | input | AW (16) | Bus address |
| wdata | input | DW (16) | Write data |
| rdata | output | DW (16) | Read data, valid while `rdata_drive` is high |
| rdata_drive | output | 1 | High when the data bus is driven; low stands for high impedance |
| cmd_err | output | 1 | Sticky flag for a command dropped because another bank was busy |

## Verification
The hardest situation to reach is a second, complete unlock-and-program sequence that lands while another bank is still busy. The busy window must outlast four full bus cycles before the rejected launch and the sticky flag can be seen. The bench overrides BUSY_CYCLES to 120 clocks and issues the second bank's sequence straight after the first launch. It then waits for the window to close and reads both banks to show that only the first word landed. A similar ordering problem applies to the abandoned-sequence case. A tracker left armed by a suppressed overlapping write is deliberately carried into the next test, which shows that a new first cycle on another bank restarts the sequence.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG} seq_st_t;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [15:0] UNLK_KEY_A  = 16'h00AA;
  localparam logic [15:0] UNLK_KEY_B  = 16'h0055;
  localparam logic [15:0] CMD_PROG    = 16'h00A0;
  localparam logic [15:0] CMD_ERASE   = 16'h0010;
  localparam logic [3:0]  PAGE_STATUS = 4'h5;
  localparam logic [3:0]  PAGE_ID     = 4'hF;
endpackage

// File: rtl/mbc_bus_if.sv
`timescale 1ns/1ps
module mbc_bus_if #(
  parameter int NB = 3,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_sel_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_req,
  output logic [BW-1:0] rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          cyc_done,
  output logic [BW-1:0] cyc_bank,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);
  // input sampling stage
  logic [NB-1:0] s_sel_n;
  logic          s_oe_n, s_we_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sel_n <= '1;
      s_oe_n  <= 1'b1;
      s_we_n  <= 1'b1;
      s_addr  <= '0;
      s_wdata <= '0;
    end else begin
      s_sel_n <= bank_sel_n;
      s_oe_n  <= out_en_n;
      s_we_n  <= wr_en_n;
      s_addr  <= addr;
      s_wdata <= wdata;
    end
  end

  logic [CW-1:0] nsel;
  logic [BW-1:0] sel_idx;
  always_comb begin
    nsel    = '0;
    sel_idx = '0;
    for (int i = 0; i < NB; i++) begin
      if (!s_sel_n[i]) begin
        nsel    = nsel + CW'(1);
        sel_idx = BW'(i);
      end
    end
  end

  logic one_sel, multi_sel;
  assign one_sel   = (nsel == CW'(1));
  assign multi_sel = (nsel > CW'(1));

  assign rd_req  = one_sel & ~s_oe_n & s_we_n;
  assign rd_bank = sel_idx;
  assign rd_addr = s_addr;

  // write cycle tracker: opens on later fall, closes on later rise
  logic          in_cyc, in_cyc_d;
  logic [BW-1:0] cb_q, cb_d;
  logic [AW-1:0] ca_q, ca_d;
  logic [DW-1:0] cd_q, cd_d;
  logic          done_q, done_d;

  always_comb begin
    in_cyc_d = in_cyc;
    cb_d     = cb_q;
    ca_d     = ca_q;
    cd_d     = cd_q;
    done_d   = 1'b0;
    if (!in_cyc) begin
      if (one_sel && !s_we_n) begin
        in_cyc_d = 1'b1;
        cb_d     = sel_idx;
        ca_d     = s_addr;
      end
    end else if (multi_sel) begin
      in_cyc_d = 1'b0;
    end else if (s_we_n && s_sel_n[cb_q]) begin
      in_cyc_d = 1'b0;
      done_d   = 1'b1;
      cd_d     = s_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cyc <= 1'b0;
      cb_q   <= '0;
      ca_q   <= '0;
      cd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      in_cyc <= in_cyc_d;
      done_q <= done_d;
      if (in_cyc_d && !in_cyc) begin
        cb_q <= cb_d;
        ca_q <= ca_d;
      end
      if (done_d) cd_q <= cd_d;
    end
  end

  assign cyc_done = done_q;
  assign cyc_bank = cb_q;
  assign cyc_addr = ca_q;
  assign cyc_data = cd_q;

  // R3: a completed cycle is a single-clock event
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  // R2: overlapping selects never complete a write cycle on the next clock
  p_overlap_no_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    multi_sel |=> !cyc_done);
endmodule

// File: rtl/mbc_cmd_seq.sv
`timescale 1ns/1ps
module mbc_cmd_seq import mbc_pkg::*; #(
  parameter int NB          = 3,
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int WORDS       = 16,
  parameter int BUSY_CYCLES = 64,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int IW  = $clog2(WORDS),
  localparam int CNW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_done,
  input  logic [BW-1:0] cyc_bank,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  output logic [NB-1:0] arr_we,
  output logic [NB-1:0] arr_erase,
  output logic [IW-1:0] arr_idx,
  output logic [DW-1:0] arr_data,
  output logic [NB-1:0] busy_vec,
  output logic          cmd_err
);
  seq_st_t        st_q, st_d, st_eff;
  logic [BW-1:0]  bank_q, bank_d;
  logic           launch_wr, launch_er, busy_any, go;
  logic [NB-1:0]  busy_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           err_q, err_d;
  logic [NB-1:0]  bank_hot;

  assign busy_any = |busy_vec;
  assign bank_hot = {{(NB-1){1'b0}}, 1'b1} << bank_q;

  always_comb begin
    st_d      = st_q;
    bank_d    = bank_q;
    launch_wr = 1'b0;
    launch_er = 1'b0;
    st_eff    = st_q;
    if (cyc_done) begin
      // a cycle on another select abandons the pending sequence
      if (st_q != SQ_IDLE && cyc_bank != bank_q) st_eff = SQ_IDLE;
      st_d = SQ_IDLE;
      case (st_eff)
        SQ_IDLE: if (cyc_addr == AW'(UNLK_ADDR_A) && cyc_data == DW'(UNLK_KEY_A)) begin
          st_d   = SQ_U1;
          bank_d = cyc_bank;
        end
        SQ_U1: if (cyc_addr == AW'(UNLK_ADDR_B) && cyc_data == DW'(UNLK_KEY_B))
          st_d = SQ_U2;
        SQ_U2: if (cyc_addr == AW'(UNLK_ADDR_A)) begin
          if (cyc_data == DW'(CMD_PROG))       st_d = SQ_PROG;
          else if (cyc_data == DW'(CMD_ERASE)) launch_er = 1'b1;
        end
        SQ_PROG: launch_wr = 1'b1;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  assign go    = (launch_wr | launch_er) & ~busy_any;
  assign err_d = err_q | ((launch_wr | launch_er) & busy_any);

  always_comb begin
    busy_d = busy_vec;
    cnt_d  = cnt_q;
    if (go) begin
      busy_d = bank_hot;
      cnt_d  = CNW'(BUSY_CYCLES - 1);
    end else if (busy_any) begin
      if (cnt_q == '0) busy_d = '0;
      else             cnt_d  = cnt_q - CNW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      bank_q   <= '0;
      busy_vec <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (cyc_done) begin
        st_q   <= st_d;
        bank_q <= bank_d;
      end
      if (go || busy_any) begin
        busy_vec <= busy_d;
        cnt_q    <= cnt_d;
      end
      err_q <= err_d;
    end
  end

  assign arr_we    = (go && launch_wr) ? bank_hot : '0;
  assign arr_erase = (go && launch_er) ? bank_hot : '0;
  assign arr_idx   = cyc_addr[IW-1:0];
  assign arr_data  = cyc_data;
  assign cmd_err   = err_q;

  // R6: never more than one bank busy
  p_single_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_vec));

  // R6: the busy bank does not change while its count is running
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && cnt_q != '0) |=> (busy_vec == $past(busy_vec)));

  // R7: the error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  // R7: an array update never happens while a bank is already busy
  p_no_update_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_any |-> (arr_we == '0 && arr_erase == '0));
endmodule

// File: rtl/mbc_bank_mem.sv
`timescale 1ns/1ps
module mbc_bank_mem #(
  parameter int DW    = 16,
  parameter int WORDS = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          erase,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mbank_cmd_ctrl.sv
`timescale 1ns/1ps
module mbank_cmd_ctrl import mbc_pkg::*; #(
  parameter int NB          = 3,
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int WORDS       = 16,
  parameter int BUSY_CYCLES = 64,
  parameter logic [DW-1:0] ID_WORD = 'h00C5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_sel_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_drive,
  output logic          cmd_err
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int IW = $clog2(WORDS);
  localparam int EE = NB - 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  logic          rd_req, cyc_done;
  logic [BW-1:0] rd_bank, cyc_bank;
  logic [AW-1:0] rd_addr, cyc_addr;
  logic [DW-1:0] cyc_data;

  mbc_bus_if #(.NB(NB), .AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_sync),
    .bank_sel_n(bank_sel_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .addr(addr), .wdata(wdata),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .cyc_done(cyc_done), .cyc_bank(cyc_bank), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
  );

  logic [NB-1:0] arr_we, arr_erase, busy_vec;
  logic [IW-1:0] arr_idx;
  logic [DW-1:0] arr_data;

  mbc_cmd_seq #(.NB(NB), .AW(AW), .DW(DW), .WORDS(WORDS), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .cyc_done(cyc_done), .cyc_bank(cyc_bank), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
    .arr_we(arr_we), .arr_erase(arr_erase), .arr_idx(arr_idx), .arr_data(arr_data),
    .busy_vec(busy_vec), .cmd_err(cmd_err)
  );

  logic [DW-1:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    mbc_bank_mem #(.DW(DW), .WORDS(WORDS)) u_mem (
      .clk(clk), .rst_n(rst_sync),
      .we(arr_we[b]), .erase(arr_erase[b]),
      .widx(arr_idx), .wdata(arr_data),
      .ridx(rd_addr[IW-1:0]), .rdata(bank_rd[b])
    );
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^rd_addr[AW-5:IW];

  // read selection: status page, identification page, or array word
  logic          drv_d, drv_q;
  logic [DW-1:0] dat_d, dat_q;
  logic [3:0]    page;
  assign page = rd_addr[AW-1:AW-4];

  always_comb begin
    drv_d = 1'b0;
    dat_d = '0;
    if (rd_req) begin
      if (rd_bank == BW'(EE) && page == PAGE_STATUS) begin
        drv_d = 1'b1;
        dat_d = DW'(busy_vec);
      end else if (rd_bank == '0 && page == PAGE_ID) begin
        if (busy_vec == '0) begin
          drv_d = 1'b1;
          dat_d = ID_WORD;
        end
      end else if (!busy_vec[rd_bank]) begin
        drv_d = 1'b1;
        dat_d = bank_rd[rd_bank];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      drv_q <= 1'b0;
      dat_q <= '0;
    end else begin
      drv_q <= drv_d;
      if (drv_d) dat_q <= dat_d;
    end
  end

  assign rdata       = dat_q;
  assign rdata_drive = drv_q;

  logic multi_raw;
  assign multi_raw = ($countones(~bank_sel_n) > 1);

  // R1: output enable high two clocks earlier keeps the bus undriven
  p_oe_high_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(out_en_n, 2) |-> !rdata_drive);

  // R2: overlapping selects two clocks earlier keep the bus undriven
  p_overlap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(multi_raw, 2) |-> !rdata_drive);
endmodule

// File: tb/mbank_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module mbank_cmd_ctrl_bench;
  localparam int BUSY = 120;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel_n;
  logic        oe_n, we_n;
  logic [15:0] addr, wdata;
  logic [15:0] rdata;
  logic        rdata_drive, cmd_err;

  always #2.5 clk = ~clk;

  mbank_cmd_ctrl #(.BUSY_CYCLES(BUSY)) u_mbank_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bank_sel_n(sel_n), .out_en_n(oe_n), .wr_en_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive), .cmd_err(cmd_err)
  );

  typedef struct {
    string       tag;
    bit          is_err;
    bit          drv;
    logic [15:0] data;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  // monitor: pops the expected item and compares with the outputs
  initial begin
    forever begin
      exp_t it;
      bit ok;
      @(sample_ev);
      it = q.pop_front();
      n_cmp++;
      if (it.is_err) ok = (cmd_err === it.drv);
      else ok = (rdata_drive === it.drv) && (!it.drv || rdata === it.data);
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: actual drive=%0b data=%h err=%0b, expected %0b/%h",
                 it.tag, rdata_drive, rdata, cmd_err, it.drv, it.data);
      end
    end
  end

  task automatic push_check(string tag, bit is_err, bit drv, logic [15:0] data);
    exp_t it;
    it.tag = tag; it.is_err = is_err; it.drv = drv; it.data = data;
    q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic idle_bus();
    sel_n = 3'b111; oe_n = 1'b1; we_n = 1'b1; addr = 16'h0000; wdata = 16'h0000;
  endtask

  // one write cycle; order 0: select falls first and rises last
  task automatic bus_write(logic [2:0] mask, logic [15:0] a, logic [15:0] d, bit order);
    @(negedge clk);
    addr = 16'hC3C3; wdata = ~d;
    if (!order) sel_n = mask; else we_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = a;
    if (!order) we_n = 1'b0; else sel_n = mask;
    repeat (3) @(negedge clk);
    addr = 16'h3C3C;
    repeat (3) @(negedge clk);
    if (!order) we_n = 1'b1; else sel_n = 3'b111;
    wdata = d;
    repeat (3) @(negedge clk);
    if (!order) sel_n = 3'b111; else we_n = 1'b1;
    repeat (3) @(negedge clk);
    wdata = 16'h9999;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [2:0] m(int b);
    return ~(3'b001 << b);
  endfunction

  task automatic program_word(int b, logic [15:0] a, logic [15:0] d, bit order);
    bus_write(m(b), 16'h5555, 16'h00AA, order);
    bus_write(m(b), 16'h2AAA, 16'h0055, order);
    bus_write(m(b), 16'h5555, 16'h00A0, order);
    bus_write(m(b), a, d, order);
  endtask

  task automatic rd(logic [2:0] mask, bit oe, logic [15:0] a, bit drv, logic [15:0] d, string tag);
    @(negedge clk);
    addr = a; sel_n = mask; oe_n = ~oe;
    repeat (4) @(negedge clk);
    push_check(tag, 1'b0, drv, d);
    sel_n = 3'b111; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_err(bit e, string tag);
    @(negedge clk);
    push_check(tag, 1'b1, e, 16'h0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual run still active, expected completion");
      finish_run();
    end
  end

  initial begin
    idle_bus();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd(m(0), 1, 16'h0003, 1, 16'hFFFF, "R11 erased word after reset");
    chk_err(0, "R11 error flag low after reset");
    rd(m(2), 1, 16'h5000, 1, 16'h0000, "R9 status idle after reset");
    rd(m(0), 0, 16'h0003, 0, 16'h0000, "R1 output enable high gives no drive");

    program_word(0, 16'h0003, 16'h1234, 0);
    repeat (BUSY + 20) @(negedge clk);
    rd(m(0), 1, 16'h0003, 1, 16'h1234, "R3 R4 program select-first order");

    program_word(1, 16'h0005, 16'hBEEF, 1);
    repeat (BUSY + 20) @(negedge clk);
    rd(m(1), 1, 16'h0005, 1, 16'hBEEF, "R3 program write-enable-first order");
    rd(m(0), 1, 16'h0005, 1, 16'hFFFF, "R4 other bank word untouched");

    program_word(2, 16'h0002, 16'h0A0A, 0);
    rd(m(0), 1, 16'h0003, 1, 16'h1234, "R8 flash bank read during EEPROM busy");
    rd(m(2), 1, 16'h5000, 1, 16'h0004, "R9 status shows EEPROM busy");
    rd(m(2), 1, 16'h0002, 0, 16'h0000, "R8 busy bank read not driven");
    rd(m(0), 1, 16'hF000, 0, 16'h0000, "R10 ID blocked while busy");
    rd(m(1), 1, 16'h0005, 1, 16'hBEEF, "R8 second flash bank read during busy");
    repeat (BUSY + 20) @(negedge clk);
    rd(m(2), 1, 16'h5000, 1, 16'h0000, "R9 status clear after busy");
    rd(m(0), 1, 16'hF000, 1, 16'h00C5, "R10 ID word while idle");
    rd(m(2), 1, 16'h0002, 1, 16'h0A0A, "R4 EEPROM word programmed");

    // mixed selects: command cycle on bank 0 in a bank 1 sequence
    bus_write(m(1), 16'h5555, 16'h00AA, 0);
    bus_write(m(1), 16'h2AAA, 16'h0055, 1);
    bus_write(m(0), 16'h5555, 16'h00A0, 0);
    bus_write(m(1), 16'h0007, 16'h5A5A, 1);
    repeat (BUSY + 20) @(negedge clk);
    rd(m(1), 1, 16'h0007, 1, 16'hFFFF, "R5 mixed-select command rejected");
    rd(m(0), 1, 16'h0007, 1, 16'hFFFF, "R5 intruding bank untouched");

    // wrong key in second cycle
    bus_write(m(0), 16'h5555, 16'h00AA, 0);
    bus_write(m(0), 16'h2AAA, 16'h0066, 0);
    bus_write(m(0), 16'h5555, 16'h00A0, 0);
    bus_write(m(0), 16'h0008, 16'h1111, 0);
    repeat (BUSY + 20) @(negedge clk);
    rd(m(0), 1, 16'h0008, 1, 16'hFFFF, "R4 wrong unlock key returns idle");

    rd(3'b100, 1, 16'h0003, 0, 16'h0000, "R2 overlapping selects not driven");
    bus_write(m(1), 16'h5555, 16'h00AA, 0);
    bus_write(m(1), 16'h2AAA, 16'h0055, 0);
    bus_write(m(1), 16'h5555, 16'h00A0, 0);
    bus_write(3'b100, 16'h0009, 16'h7777, 0);
    repeat (BUSY + 20) @(negedge clk);
    rd(m(1), 1, 16'h0009, 1, 16'hFFFF, "R2 overlapping write ignored");
    chk_err(0, "R7 no error before conflict");

    // conflict: second bank command during busy (restarts armed tracker)
    program_word(0, 16'h0001, 16'h1111, 0);
    program_word(1, 16'h0001, 16'h2222, 1);
    chk_err(1, "R7 error set by command during busy");
    repeat (BUSY + 20) @(negedge clk);
    rd(m(1), 1, 16'h0001, 1, 16'hFFFF, "R7 rejected command left array");
    rd(m(0), 1, 16'h0001, 1, 16'h1111, "R6 first launched command landed");
    program_word(1, 16'h0001, 16'h2222, 0);
    repeat (BUSY + 20) @(negedge clk);
    rd(m(1), 1, 16'h0001, 1, 16'h2222, "R6 command accepted after busy ends");
    chk_err(1, "R7 error flag sticky");

    bus_write(m(0), 16'h5555, 16'h00AA, 1);
    bus_write(m(0), 16'h2AAA, 16'h0055, 1);
    bus_write(m(0), 16'h5555, 16'h0010, 1);
    rd(m(2), 1, 16'h5000, 1, 16'h0001, "R6 erase marks bank 0 busy");
    repeat (BUSY + 20) @(negedge clk);
    rd(m(0), 1, 16'h0003, 1, 16'hFFFF, "R4 bank erase clears word");
    rd(m(1), 1, 16'h0005, 1, 16'hBEEF, "R4 erase leaves other bank");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule